// File: doc/BRIEF.md
# Multi-Mode Timer Channel

A single timer channel whose behaviour is chosen by a 4-bit mode code in its control word. The code sets three things together: where the counter takes its clock, which way the one bidirectional timer pin points, and what the channel does with that pin. Output uses are single-cycle pulses, toggles and pulse-width modulation, each with a watchdog variant. Input uses are counting pin events, measuring high time, measuring period and capturing the count on a rising edge. When the code is zero the timer still counts, and the pin becomes a plain general-purpose I/O line.

Software reaches the channel through a small register port. Address 0 is the control word, address 1 the load value, address 2 the compare value and address 3 the read-only capture value. The counter is held at the load value while the channel is disabled and starts from it on enable. Events set one sticky interrupt flag, which software clears by writing a one. The pin input passes through a two-flop synchronizer and an edge detector before the counter sees it, so its events must be slower than a quarter of the clock. The data width `CNT_W` must be at least 10, so that the control word fits.

Top module: `mtc_channel`

## Requirements
- R1: After reset, the control word, capture and load registers read 0, `pin_oe` is 0 and `irq` is 0.
- R2: Control word layout: bit 0 is reserved, bit 1 is enable, bits 5:2 are the mode, bit 6 is the GPIO output data, bit 7 is the GPIO direction (1 = drive), bit 8 is the flag (writing 1 clears it) and bit 9 is the synchronized pin level. Bit 0 always reads 0, whatever was written to it.
- R3: A write to the mode field is ignored while enable reads 1. A write made while the channel is disabled takes effect, including a write that sets enable in the same access.
- R4: `pin_oe` is 1 for modes 1, 2, 7, 9 and 10. It is 0 for modes 3, 4, 5 and 6 and for the reserved codes 8 and 11 to 15. In mode 0 `pin_oe` follows bit 7 and `pin_out` follows bit 6.
- R5: In modes 0, 1, 2, 9 and 10 the counter advances once per clock from the load value. On the edge where it equals the compare value, it sets the flag and reloads. With load 0 and compare C, the flag rises C+1 clocks after the enabling write.
- R6: Modes 1 and 9 drive `pin_out` high for exactly one clock after each match. Modes 2 and 10 invert `pin_out` on each match, starting from 0.
- R7: Mode 3 advances the counter once per rising edge of the synchronized pin, which is applied two clocks after the pin rises. The flag is set when the count equals the compare value at such an edge.
- R8: Mode 4 counts clocks while the synchronized pin is high. On its falling edge the count goes to capture, the flag is set and the counter reloads.
- R9: Mode 5 captures the number of clocks between successive rising edges of the pin and sets the flag on each such edge.
- R10: Mode 6 runs the counter freely from the load value and copies the count to capture, setting the flag, on each synchronized rising edge.
- R11: Mode 7 holds `pin_out` high from reload until the count equals the compare value, then low until the count reaches all ones, where it reloads and goes high again. The match also sets the flag.
- R12: In modes 9 and 10, writing the load register while enabled restarts the counter from the written value. Regular restarts keep the pin and the flag quiet.
- R13: When a flag-setting event and a software clear fall on the same clock, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 load, 2 compare, 3 capture) |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr`, combinational |
| pin_in | input | 1 | Timer pin input level |
| pin_out | output | 1 | Timer pin output level |
| pin_oe | output | 1 | Timer pin output enable |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The counter's match can set the flag on the same clock in which software writes a one to clear it. The bench sets up a count with a known length and then times a clear write so that its edge coincides with the match edge. The flag must still read as set afterwards. A second clear on a quiet clock must then drop it, so the bench can tell a correct priority from a flag that cannot be cleared at all.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    typedef enum logic [3:0] {
        MD_GPIO      = 4'd0,
        MD_PULSE     = 4'd1,
        MD_TOGGLE    = 4'd2,
        MD_EVENT     = 4'd3,
        MD_WIDTH     = 4'd4,
        MD_PERIOD    = 4'd5,
        MD_CAPTURE   = 4'd6,
        MD_PWM       = 4'd7,
        MD_WD_PULSE  = 4'd9,
        MD_WD_TOGGLE = 4'd10
    } mode_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LOAD = 2'd1;
    localparam logic [1:0] A_CMP  = 2'd2;
    localparam logic [1:0] A_CAP  = 2'd3;

    localparam int B_EN   = 1;
    localparam int B_MODE = 2;
    localparam int B_GDAT = 6;
    localparam int B_GDIR = 7;
    localparam int B_FLAG = 8;
    localparam int B_PIN  = 9;

    function automatic logic drives_pin(input logic [3:0] m);
        return m == 4'd1 || m == 4'd2 || m == 4'd7 || m == 4'd9 || m == 4'd10;
    endfunction

endpackage

// File: rtl/mtc_sync.sv
module mtc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/mtc_core.sv
module mtc_core
    import mtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  mode_e            mode,
    input  logic [CNT_W-1:0] load,
    input  logic [CNT_W-1:0] cmp,
    input  logic             lvl,
    input  logic             rise,
    input  logic             fall,
    input  logic             kick,
    input  logic [CNT_W-1:0] kick_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap,
    output logic             flag,
    output logic             drv
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             flag;
        logic             pulse;
        logic             tog;
        logic             pwm;
    } core_t;

    core_t s_d, s_q;
    logic  match, cap_ev, tick;

    always_comb begin
        s_d    = s_q;
        match  = 1'b0;
        cap_ev = 1'b0;
        tick   = 1'b0;
        if (!en) begin
            s_d.cnt   = load;
            s_d.pulse = 1'b0;
            s_d.tog   = 1'b0;
            s_d.pwm   = 1'b1;
        end else begin
            s_d.pulse = 1'b0;
            case (mode)
                MD_GPIO, MD_PULSE, MD_TOGGLE, MD_EVENT, MD_WD_PULSE, MD_WD_TOGGLE: begin
                    tick = (mode == MD_EVENT) ? rise : 1'b1;
                    if (tick) begin
                        if (s_q.cnt == cmp) begin
                            match   = 1'b1;
                            s_d.cnt = load;
                        end else begin
                            s_d.cnt = s_q.cnt + ONE;
                        end
                    end
                    if ((mode == MD_WD_PULSE || mode == MD_WD_TOGGLE) && kick)
                        s_d.cnt = kick_val;
                end
                MD_PWM: begin
                    if (s_q.cnt == cmp) begin
                        match   = 1'b1;
                        s_d.pwm = 1'b0;
                    end
                    if (s_q.cnt == CNT_MAX) begin
                        s_d.cnt = load;
                        s_d.pwm = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
                MD_WIDTH: begin
                    if (fall) begin
                        cap_ev  = 1'b1;
                        s_d.cap = s_q.cnt;
                        s_d.cnt = load;
                    end else if (lvl) begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
                MD_PERIOD: begin
                    if (rise) begin
                        cap_ev  = 1'b1;
                        s_d.cap = s_q.cnt;
                        s_d.cnt = load + ONE;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
                MD_CAPTURE: begin
                    s_d.cnt = s_q.cnt + ONE;
                    if (rise) begin
                        cap_ev  = 1'b1;
                        s_d.cap = s_q.cnt;
                    end
                end
                default: ;
            endcase
            if (mode == MD_PULSE || mode == MD_WD_PULSE)   s_d.pulse = match;
            if (mode == MD_TOGGLE || mode == MD_WD_TOGGLE) s_d.tog   = s_q.tog ^ match;
        end
        if (match || cap_ev) s_d.flag = 1'b1;
        else if (flag_clr)   s_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, cap: '0, flag: 1'b0, pulse: 1'b0, tog: 1'b0, pwm: 1'b1};
        else        s_q <= s_d;
    end

    always_comb begin
        case (mode)
            MD_PULSE, MD_WD_PULSE:   drv = s_q.pulse;
            MD_TOGGLE, MD_WD_TOGGLE: drv = s_q.tog;
            MD_PWM:                  drv = s_q.pwm;
            default:                 drv = 1'b0;
        endcase
    end

    assign cap  = s_q.cap;
    assign flag = s_q.flag;

    // R6: a pulse on the pin is always accompanied by a raised flag
    p_pulse_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MD_PULSE || mode == MD_WD_PULSE) && s_q.pulse) |-> s_q.flag);

    // R8: capture register only moves together with the flag
    p_cap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.cap) |-> s_q.flag);

endmodule

// File: rtl/mtc_channel.sv
module mtc_channel
    import mtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq
);
    typedef struct packed {
        logic             en;
        logic [3:0]       mode;
        logic             gdat;
        logic             gdir;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t r_d, r_q;
    logic  lvl, rise, fall, drv, flag, flag_clr, kick;
    logic  [CNT_W-1:0] cap;
    mode_e mode;

    assign mode     = mode_e'(r_q.mode);
    assign flag_clr = reg_wr && reg_addr == A_CTRL && reg_wdata[B_FLAG];
    assign kick     = reg_wr && reg_addr == A_LOAD && r_q.en;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    r_d.en   = reg_wdata[B_EN];
                    r_d.gdat = reg_wdata[B_GDAT];
                    r_d.gdir = reg_wdata[B_GDIR];
                    if (!r_q.en) r_d.mode = reg_wdata[B_MODE +: 4];
                end
                A_LOAD:  r_d.load = reg_wdata;
                A_CMP:   r_d.cmp  = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    mtc_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in),
        .level(lvl), .rise(rise), .fall(fall)
    );

    mtc_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .en(r_q.en), .mode(mode),
        .load(r_q.load), .cmp(r_q.cmp), .lvl(lvl), .rise(rise), .fall(fall),
        .kick(kick), .kick_val(reg_wdata), .flag_clr(flag_clr),
        .cap(cap), .flag(flag), .drv(drv)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_EN]        = r_q.en;
                reg_rdata[B_MODE +: 4] = r_q.mode;
                reg_rdata[B_GDAT]      = r_q.gdat;
                reg_rdata[B_GDIR]      = r_q.gdir;
                reg_rdata[B_FLAG]      = flag;
                reg_rdata[B_PIN]       = lvl;
            end
            A_LOAD:  reg_rdata = r_q.load;
            A_CMP:   reg_rdata = r_q.cmp;
            default: reg_rdata = cap;
        endcase
    end

    assign pin_oe  = (r_q.mode == 4'd0) ? r_q.gdir : drives_pin(r_q.mode);
    assign pin_out = (r_q.mode == 4'd0) ? r_q.gdat : drv;
    assign irq     = flag;

    // R3: mode is frozen across any clock where the channel was enabled
    p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.en |=> $stable(r_q.mode));

    // R4: input modes never drive the pin
    p_input_no_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode >= 4'd3 && r_q.mode <= 4'd6) |-> !pin_oe);

endmodule

// File: tb/mtc_channel_tb_top.sv
`timescale 1ns/100ps
module mtc_channel_tb_top;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         pin_in = 1'b0;
    logic         pin_out, pin_oe, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mtc_channel #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ctl(input int en, input int mode);
        return W'((mode << 2) | (en << 1));
    endfunction

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a; #0.5;
        v = int'(reg_rdata);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; pin_in = 1'b0; reg_wr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic setup(input int ld, input int cp);
        do_reset();
        wr(2'd1, W'(ld));
        wr(2'd2, W'(cp));
    endtask

    task automatic pin_pulse(input int hi, input int lo);
        @(negedge clk); pin_in = 1'b1;
        repeat (hi) @(negedge clk);
        pin_in = 1'b0;
        repeat (lo - 1) @(negedge clk);
    endtask

    task automatic t_reset;
        int v;
        do_reset();
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd3, v); chk("R1 capture", v, 0);
        rd(2'd1, v); chk("R1 load", v, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_resv;
        int v;
        do_reset();
        wr(2'd0, W'(1) | ctl(0, 1));
        rd(2'd0, v); chk("R2 reserved bit reads zero", v, 4);
    endtask

    task automatic t_dir;
        int oe_exp [16] = '{0,1,1,0,0,0,0,1,0,1,1,0,0,0,0,0};
        do_reset();
        for (int m = 1; m < 16; m++) begin
            wr(2'd0, ctl(0, m));
            chk($sformatf("R4 pin_oe mode %0d", m), pin_oe, oe_exp[m]);
        end
        wr(2'd0, W'(32'h0C0));
        chk("R4 gpio oe", pin_oe, 1);
        chk("R4 gpio out high", pin_out, 1);
        wr(2'd0, W'(32'h080));
        chk("R4 gpio out low", pin_out, 0);
        wr(2'd0, W'(32'h040));
        chk("R4 gpio released", pin_oe, 0);
    endtask

    task automatic t_pulse;
        setup(0, 3);
        wr(2'd0, ctl(1, 1));
        repeat (3) @(posedge clk); #1;
        chk("R5 flag before match", irq, 0);
        chk("R6 pin before match", pin_out, 0);
        @(posedge clk); #1;
        chk("R5 flag at match", irq, 1);
        chk("R6 pulse high", pin_out, 1);
        @(posedge clk); #1;
        chk("R6 pulse one clock", pin_out, 0);
    endtask

    task automatic t_toggle;
        setup(0, 3);
        wr(2'd0, ctl(1, 2));
        repeat (3) @(posedge clk); #1;
        chk("R6 toggle start", pin_out, 0);
        @(posedge clk); #1;
        chk("R6 toggle first", pin_out, 1);
        repeat (3) @(posedge clk); #1;
        chk("R6 toggle hold", pin_out, 1);
        @(posedge clk); #1;
        chk("R6 toggle second", pin_out, 0);
    endtask

    task automatic t_frozen;
        int v;
        do_reset();
        wr(2'd0, ctl(1, 1));
        wr(2'd0, ctl(1, 2));
        rd(2'd0, v); chk("R3 mode kept while enabled", (v >> 2) & 15, 1);
        wr(2'd0, ctl(0, 2));
        rd(2'd0, v); chk("R3 mode ignored on disabling write", (v >> 2) & 15, 1);
        wr(2'd0, ctl(0, 2));
        rd(2'd0, v); chk("R3 mode taken while disabled", (v >> 2) & 15, 2);
    endtask

    task automatic t_event;
        setup(0, 2);
        wr(2'd0, ctl(1, 3));
        repeat (6) @(posedge clk); #1;
        chk("R7 no count without edges", irq, 0);
        pin_pulse(2, 2);
        pin_pulse(2, 2);
        repeat (3) @(negedge clk);
        chk("R7 two edges no match", irq, 0);
        pin_pulse(2, 2);
        repeat (3) @(negedge clk);
        chk("R7 third edge matches", irq, 1);
    endtask

    task automatic t_width;
        int v;
        setup(0, 1000);
        wr(2'd0, ctl(1, 4));
        repeat (3) @(negedge clk);
        pin_in = 1'b1;
        repeat (5) @(negedge clk);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd3, v); chk("R8 width capture", v, 5);
        chk("R8 width flag", irq, 1);
    endtask

    task automatic t_period;
        int v;
        setup(0, 1000);
        wr(2'd0, ctl(1, 5));
        pin_pulse(3, 3);
        pin_pulse(3, 3);
        pin_pulse(3, 3);
        rd(2'd3, v); chk("R9 period capture", v, 6);
        chk("R9 period flag", irq, 1);
    endtask

    task automatic t_capture;
        int v;
        setup(0, 1000);
        wr(2'd0, ctl(1, 6));
        repeat (2) @(posedge clk);
        @(negedge clk); pin_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd3, v); chk("R10 captured count", v, 4);
        chk("R10 capture flag", irq, 1);
    endtask

    task automatic t_pwm;
        setup(0, 2);
        wr(2'd0, ctl(1, 7));
        repeat (2) @(posedge clk); #1;
        chk("R11 high before match", pin_out, 1);
        @(posedge clk); #1;
        chk("R11 low after match", pin_out, 0);
        chk("R11 match flag", irq, 1);
        repeat (1020) @(posedge clk); #1;
        chk("R11 low before overflow", pin_out, 0);
        @(posedge clk); #1;
        chk("R11 high after overflow", pin_out, 1);
    endtask

    task automatic t_wdog;
        int quiet = 1;
        setup(0, 5);
        wr(2'd0, ctl(1, 9));
        for (int k = 0; k < 6; k++) begin
            repeat (2) @(posedge clk); #1;
            if (irq || pin_out) quiet = 0;
            wr(2'd1, W'(0));
        end
        chk("R12 kicked watchdog quiet", quiet, 1);
        repeat (8) @(posedge clk); #1;
        chk("R12 expiry flag", irq, 1);
    endtask

    task automatic t_flag;
        setup(0, 3);
        wr(2'd0, ctl(1, 0));
        repeat (3) @(posedge clk);
        wr(2'd0, ctl(1, 0) | W'(32'h100));
        chk("R13 set wins over clear", irq, 1);
        wr(2'd0, ctl(1, 0) | W'(32'h100));
        chk("R13 clear on quiet clock", irq, 0);
    endtask

    initial begin
        fork
            begin
                t_reset(); t_resv(); t_dir(); t_pulse(); t_toggle(); t_frozen();
                t_event(); t_width(); t_period(); t_capture(); t_pwm();
                t_wdog(); t_flag();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule